// File: doc/BRIEF.md
# Synchronous Serial Receive Engine

This block receives 8-bit frames over a clocked serial link, least significant bit first. It has two modes. In master mode it makes the serial clock itself from a baud tick and drives that clock out of the block. In slave mode it follows a serial clock from outside the block. That clock is brought into the system clock domain and edge-detected there. In both modes each bit is captured once, and the captured bit is shifted into the frame register on a later event. When the eighth bit arrives, the frame is copied into a receive buffer and a one-cycle completion pulse is raised.

The block owns the receive-enable bit. Software writes the bit through a write strobe and a data bit. In master mode the hardware clears the bit when a frame completes, so each write of 1 yields one frame. In slave mode the bit stays set, and reception re-arms by itself for back-to-back frames. Writing 0 aborts a partly received frame and empties the buffer. An overrun flag records that a frame was overwritten before it was read. A write to the enable bit clears the overrun flag.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset the outputs are as follows: `rx_en`, `rx_done`, `overrun`, `sclk_oe` and `sclk_out` are 0, and `rx_buf` is all zeros.
- R2: In master mode a 2-bit phase counter advances on each baud tick. `sclk_out` is low in phases 0 and 1 and high in phases 2 and 3, so one serial clock period is four ticks. A frame starts only on a tick that wraps the phase to 0 while `rx_en` is 1. `sclk_oe` rises at that start with `sclk_out` low. Outside a frame, both `sclk_oe` and `sclk_out` are 0.
- R3: In master mode `sd_in` is captured on the tick that enters phase 2, which is the rising edge of `sclk_out`. The captured bit is shifted in on the tick that enters phase 3. The first bit received becomes bit 0 of the byte.
- R4: In master mode, when a frame completes, `rx_en` goes to 0 and `sclk_oe` goes to 0 on the same clock edge that raises `rx_done`. The exception is a write to the enable bit in that same cycle.
- R5: In slave mode `sclk_in` passes through a two-flop synchronizer. A detected falling edge captures `sd_in`. The next detected rising edge shifts the captured bit in, least significant bit first. `rx_done` goes high on the third rising clock edge after `sclk_in` rises for the eighth bit.
- R6: In slave mode `rx_en` stays 1 after a frame completes. Further serial clock edges receive the next frame with no new write.
- R7: `rx_done` is high for exactly one cycle per frame, and `rx_buf` holds the new byte in that same cycle.
- R8: `overrun` is set when a frame completes while the previous frame is still unread, and the new byte replaces the old one. A `buf_rd` pulse in the completion cycle counts as a read that comes first, so that case does not set `overrun`.
- R9: `overrun` stays set through later reads and frames. It clears only on an enable write (`en_wr`=1, either value) or on reset, and the clear takes priority over a new set.
- R10: Writing 0 to the enable bit clears `rx_buf` to zero, drops the unread status, and discards any partly received bits. The next frame after re-enabling starts from bit 0.
- R11: When `mode_master` is 0, `sclk_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle baud tick that clocks the master phase counter |
| sd_in | input | 1 | Serial data in |
| sclk_in | input | 1 | External serial clock (slave mode), idle high |
| mode_master | input | 1 | 1 = master mode, 0 = slave mode |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| buf_rd | input | 1 | Buffer-read strobe; marks the buffer as read |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Output enable for `sclk_out` |
| rx_en | output | 1 | Current state of the receive-enable bit |
| rx_buf | output | DATA_W | Last received byte |
| rx_done | output | 1 | One-cycle frame-complete pulse |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The slave path is checked with exact latency. The bench raises `sclk_in` for the last bit at a falling clock edge. It then expects `rx_done` low at the next two falling edges, high at the third (with the new byte in `rx_buf`), and low again at the fourth. Abort, overrun clearing and the auto-cleared enable appear on the first edge after their cause, so they are read at the falling edge that follows that edge. The master clock shape is checked as counts. The bench issues a baud tick every four clocks, so after `sclk_oe` rises it expects exactly eight falling-edge samples with `sclk_out` low, then exactly eight with it high. Master frames wait for the clock levels seen at the ports, each under a timeout, rather than for a fixed cycle.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {
    SRX_SLAVE  = 1'b0,
    SRX_MASTER = 1'b1
  } srx_mode_e;

  // master divider: four phases per serial clock period
  localparam int               SRX_PH_W      = 2;
  localparam logic [SRX_PH_W-1:0] SRX_PH_SAMPLE = 2'd2;
  localparam logic [SRX_PH_W-1:0] SRX_PH_SHIFT  = 2'd3;
endpackage

// File: rtl/srx_clkgen.sv
// Produces the capture and shift events for either mode and drives the
// master serial clock.
module srx_clkgen
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic baud_tick,
  input  logic sclk_in,
  input  logic is_master,
  input  logic en,
  input  logic frame_done,
  output logic samp_evt,
  output logic shift_evt,
  output logic sclk_out,
  output logic sclk_oe
);
  localparam int TOP = SYNC_STAGES - 1;

  // slave path: synchronizer plus edge detect
  logic [TOP:0] sync_q;
  logic         prev_q;
  logic         s_fall, s_rise;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[TOP-1:0], sclk_in};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= sclk_in;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[TOP];
  end

  assign s_fall = prev_q & ~sync_q[TOP];
  assign s_rise = ~prev_q & sync_q[TOP];

  // master path: tick-driven phase counter
  logic [SRX_PH_W-1:0] phase_q, phase_n;
  logic                active_q, active_n;
  logic                m_start, m_samp, m_shift;

  always_comb begin
    phase_n = baud_tick ? phase_q + 1'b1 : phase_q;
    m_start = baud_tick && (phase_n == '0) && !active_q && en && is_master;
    m_samp  = active_q && baud_tick && (phase_n == SRX_PH_SAMPLE);
    m_shift = active_q && baud_tick && (phase_n == SRX_PH_SHIFT);
    if (!en || !is_master || frame_done) active_n = 1'b0;
    else if (m_start)                     active_n = 1'b1;
    else                                  active_n = active_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      active_q <= 1'b0;
      sclk_out <= 1'b0;
      sclk_oe  <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      active_q <= active_n;
      sclk_out <= active_n && phase_n[SRX_PH_W-1];
      sclk_oe  <= active_n;
    end
  end

  assign samp_evt  = is_master ? m_samp  : s_fall;
  assign shift_evt = is_master ? m_shift : s_rise;
endmodule

// File: rtl/srx_shifter.sv
// Captures one bit per capture event and shifts it in, LSB first, on the
// following shift event.
module srx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate,
  input  logic              clear,
  input  logic              samp_evt,
  input  logic              shift_evt,
  input  logic              sd_in,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data
);
  localparam int               CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

  logic              samp_q;
  logic              held_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_shift;

  assign do_shift   = gate && shift_evt && held_q;
  assign frame_done = do_shift && (cnt_q == LAST);
  assign frame_data = {samp_q, shreg_q[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clear || !gate) begin
      samp_q  <= 1'b0;
      held_q  <= 1'b0;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (samp_evt) begin
      samp_q <= sd_in;
      held_q <= 1'b1;
    end else if (do_shift) begin
      shreg_q <= frame_data;
      held_q  <= 1'b0;
      cnt_q   <= frame_done ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/srx_rxbuf.sv
// Receive buffer with unread tracking, completion pulse and sticky overrun.
module srx_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              en_wr,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              buf_rd,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_done,
  output logic              overrun
);
  logic unread_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf   <= '0;
      unread_q <= 1'b0;
      rx_done  <= 1'b0;
    end else begin
      rx_done <= load && !abort;
      if (abort) begin
        rx_buf   <= '0;
        unread_q <= 1'b0;
      end else if (load) begin
        rx_buf   <= load_data;
        unread_q <= 1'b1;
      end else if (buf_rd) begin
        unread_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || en_wr)                          overrun <= 1'b0;
    else if (load && !abort && unread_q && !buf_rd) overrun <= 1'b1;
  end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              sd_in,
  input  logic              sclk_in,
  input  logic              mode_master,
  input  logic              en_wr,
  input  logic              en_wdata,
  input  logic              buf_rd,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              rx_en,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_done,
  output logic              overrun
);
  srx_mode_e         mode;
  logic              is_master;
  logic              samp_evt, shift_evt;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              abort;
  logic              load;

  assign mode      = srx_mode_e'(mode_master);
  assign is_master = (mode == SRX_MASTER);
  assign abort     = en_wr && !en_wdata;
  assign load      = frame_done && !abort;

  // enable bit: software write wins, master frame end self-clears
  always_ff @(posedge clk) begin
    if (rst)                          rx_en <= 1'b0;
    else if (en_wr)                   rx_en <= en_wdata;
    else if (frame_done && is_master) rx_en <= 1'b0;
  end

  srx_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clkgen (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .sclk_in    (sclk_in),
    .is_master  (is_master),
    .en         (rx_en),
    .frame_done (frame_done),
    .samp_evt   (samp_evt),
    .shift_evt  (shift_evt),
    .sclk_out   (sclk_out),
    .sclk_oe    (sclk_oe)
  );

  srx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk        (clk),
    .rst        (rst),
    .gate       (rx_en),
    .clear      (abort),
    .samp_evt   (samp_evt),
    .shift_evt  (shift_evt),
    .sd_in      (sd_in),
    .frame_done (frame_done),
    .frame_data (frame_data)
  );

  srx_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk       (clk),
    .rst       (rst),
    .abort     (abort),
    .en_wr     (en_wr),
    .load      (load),
    .load_data (frame_data),
    .buf_rd    (buf_rd),
    .rx_buf    (rx_buf),
    .rx_done   (rx_done),
    .overrun   (overrun)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_master,
  input logic              en_wr,
  input logic              en_wdata,
  input logic              sclk_out,
  input logic              sclk_oe,
  input logic              rx_en,
  input logic [DATA_W-1:0] rx_buf,
  input logic              rx_done,
  input logic              overrun
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);

  // R4
  auto_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && $past(mode_master) && !$past(en_wr)) |-> !rx_en);

  // R6
  slave_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !$past(mode_master) && !$past(en_wr)) |-> rx_en);

  // R8
  ovr_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> rx_done);

  // R9
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> !overrun);

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (en_wr && !en_wdata) |=> (rx_buf == '0 && !rx_done));

  // R11
  slave_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_master && !$past(mode_master)) |-> !sclk_oe);

  // R2
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_oe) |-> (!sclk_out && $past(rx_en)));

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !sclk_oe |-> !sclk_out);
endmodule

bind sync_serial_rx srx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_master (mode_master),
  .en_wr       (en_wr),
  .en_wdata    (en_wdata),
  .sclk_out    (sclk_out),
  .sclk_oe     (sclk_oe),
  .rx_en       (rx_en),
  .rx_buf      (rx_buf),
  .rx_done     (rx_done),
  .overrun     (overrun)
);

// File: tb/sync_serial_rx_test.sv
`timescale 1ns/100ps
module sync_serial_rx_test;
  localparam int DW = 8;
  localparam int NV = 7;
  // vector format: {master, read_before, data}
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'hA5},
    {1'b1, 1'b0, 8'h3C},
    {1'b1, 1'b1, 8'h81},
    {1'b0, 1'b0, 8'h5A},
    {1'b0, 1'b0, 8'hFF},
    {1'b1, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'hC3}
  };

  logic clk = 1'b0, rst = 1'b1, baud_tick = 1'b0, sd_in = 1'b0, sclk_in = 1'b1;
  logic mode_master = 1'b0, en_wr = 1'b0, en_wdata = 1'b0, buf_rd = 1'b0;
  logic sclk_out, sclk_oe, rx_en, rx_done, overrun;
  logic [DW-1:0] rx_buf;

  int checks = 0, failures = 0, done_cnt = 0, tick_div = 0;
  bit finished = 1'b0;

  sync_serial_rx #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .sd_in(sd_in), .sclk_in(sclk_in),
    .mode_master(mode_master), .en_wr(en_wr), .en_wdata(en_wdata), .buf_rd(buf_rd),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rx_en(rx_en), .rx_buf(rx_buf),
    .rx_done(rx_done), .overrun(overrun)
  );

  always #2.5 clk = ~clk;

  // baud tick every fourth clock
  always @(negedge clk) begin
    tick_div  = (tick_div + 1) % 4;
    baud_tick = (tick_div == 0);
  end

  always @(negedge clk) if (rx_done === 1'b1) done_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_en(input logic v);
    @(negedge clk); en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); buf_rd = 1'b1;
    @(negedge clk); buf_rd = 1'b0;
  endtask

  task automatic wait_lvl(input bit use_oe, input logic lvl, input string req);
    int g = 0;
    while (((use_oe ? sclk_oe : sclk_out) !== lvl) && g < 400) begin
      @(negedge clk); g++;
    end
    if (g >= 400) chk({req, " clock level timeout"}, 32'(!lvl), 32'(lvl));
  endtask

  task automatic wait_done(input int start, input string req);
    int g = 0;
    while (done_cnt == start && g < 400) begin @(negedge clk); g++; end
    if (g >= 400) chk({req, " completion timeout"}, 0, 1);
  endtask

  task automatic send_master(input logic [7:0] d);
    int s = done_cnt;
    wait_lvl(1'b1, 1'b1, "R2");
    sd_in = d[0];
    for (int i = 1; i < 8; i++) begin
      wait_lvl(1'b0, 1'b1, "R2");
      wait_lvl(1'b0, 1'b0, "R2");
      sd_in = d[i];
    end
    wait_done(s, "R3");
  endtask

  task automatic send_slave(input logic [7:0] d, input int nb, input bit lat, input bit rd_end);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); sclk_in = 1'b0; sd_in = d[i];
      repeat (8) @(negedge clk);
      sclk_in = 1'b1;
      if (i == 7) begin
        @(negedge clk);
        @(negedge clk);
        if (rd_end) buf_rd = 1'b1;
        if (lat) chk("R5 done not yet two edges after last rise", 32'(rx_done), 0);
        @(negedge clk);
        buf_rd = 1'b0;
        if (lat) begin
          chk("R5 done on third edge after last rise", 32'(rx_done), 1);
          chk("R7 buffer valid with done", 32'(rx_buf), 32'(d));
        end
        @(negedge clk);
        if (lat) chk("R7 done lasts one cycle", 32'(rx_done), 0);
        repeat (5) @(negedge clk);
      end else begin
        repeat (7) @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit unread_m = 1'b0, ovr_m = 1'b0;
    int s, n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_en", 32'(rx_en), 0);
    chk("R1 rx_buf", 32'(rx_buf), 0);
    chk("R1 rx_done", 32'(rx_done), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 sclk_oe", 32'(sclk_oe), 0);
    chk("R1 sclk_out", 32'(sclk_out), 0);

    // table-driven frames
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][8]) begin pulse_rd(); unread_m = 1'b0; end
      @(negedge clk); mode_master = VEC[v][9];
      wr_en(1'b1); ovr_m = 1'b0;
      s = done_cnt;
      if (VEC[v][9]) send_master(VEC[v][7:0]);
      else           send_slave(VEC[v][7:0], 8, 1'b0, 1'b0);
      ovr_m = ovr_m | unread_m; unread_m = 1'b1;
      chk(VEC[v][9] ? "R3 master byte" : "R5 slave byte", 32'(rx_buf), 32'(VEC[v][7:0]));
      chk("R8 overrun per model", 32'(overrun), 32'(ovr_m));
      chk("R7 one done per frame", 32'(done_cnt - s), 1);
      if (VEC[v][9]) begin
        chk("R4 enable self-cleared", 32'(rx_en), 0);
        chk("R4 clock released", 32'(sclk_oe), 0);
      end else begin
        chk("R6 enable kept", 32'(rx_en), 1);
        chk("R11 no clock drive in slave", 32'(sclk_oe), 0);
        wr_en(1'b0); unread_m = 1'b0;
        chk("R10 abort clears buffer", 32'(rx_buf), 0);
      end
    end

    // slave back-to-back, latency, overrun stickiness
    pulse_rd();
    @(negedge clk); mode_master = 1'b0;
    wr_en(1'b1);
    send_slave(8'h6B, 8, 1'b1, 1'b0);
    chk("R8 no overrun after read", 32'(overrun), 0);
    send_slave(8'h94, 8, 1'b0, 1'b0);
    chk("R6 second frame without rewrite", 32'(rx_en), 1);
    chk("R8 new byte overwrites", 32'(rx_buf), 32'h94);
    chk("R8 overrun on unread", 32'(overrun), 1);
    pulse_rd();
    chk("R9 read leaves overrun", 32'(overrun), 1);
    send_slave(8'h11, 8, 1'b0, 1'b0);
    chk("R9 overrun still set", 32'(overrun), 1);
    wr_en(1'b1);
    chk("R9 enable write clears overrun", 32'(overrun), 0);
    send_slave(8'hEE, 8, 1'b1, 1'b1);
    chk("R8 same-cycle read counts first", 32'(overrun), 0);
    chk("R8 byte after same-cycle read", 32'(rx_buf), 32'hEE);
    chk("R11 oe low in slave", 32'(sclk_oe), 0);

    // abort mid-frame
    send_slave(8'h07, 3, 1'b0, 1'b0);
    wr_en(1'b0);
    chk("R10 abort empties buffer", 32'(rx_buf), 0);
    chk("R10 abort drops enable", 32'(rx_en), 0);
    wr_en(1'b1);
    send_slave(8'h96, 8, 1'b0, 1'b0);
    chk("R10 fresh frame after re-arm", 32'(rx_buf), 32'h96);
    chk("R10 no overrun after abort", 32'(overrun), 0);
    wr_en(1'b0);

    // master clock shape
    @(negedge clk); mode_master = 1'b1; sd_in = 1'b1;
    chk("R2 idle clock off", 32'(sclk_oe), 0);
    s = done_cnt;
    wr_en(1'b1);
    wait_lvl(1'b1, 1'b1, "R2");
    chk("R2 clock low at start", 32'(sclk_out), 0);
    n = 0;
    while (sclk_out === 1'b0 && n < 100) begin n++; @(negedge clk); end
    chk("R2 low half is two ticks", 32'(n), 8);
    n = 0;
    while (sclk_out === 1'b1 && n < 100) begin n++; @(negedge clk); end
    chk("R2 high half is two ticks", 32'(n), 8);
    wait_done(s, "R3");
    chk("R3 all-ones byte", 32'(rx_buf), 32'hFF);
    chk("R4 enable self-cleared", 32'(rx_en), 0);
    chk("R4 oe off after frame", 32'(sclk_oe), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule